// File: doc/BRIEF.md
# Interrupt Enable and Status Unit

This unit gathers four event pulses from the rest of a host-facing command interface and turns them into a single interrupt line for the host. The events are data available, status valid, locality change and command ready. Each event sets a sticky bit in a status register. Software reads that register and clears the bits it has handled by writing ones to them. A separate enable register decides which sources may raise the interrupt, and its top bit is a master switch over all of them. An 8-bit vector register is plain scratch storage that software uses to record which interrupt number it picked. A read-only capability word reports which sources exist and how the output line triggers.

All four registers sit at fixed byte offsets in a small register window:

| Register | Offset | Access |
|---|---|---|
| enable | 0x08 | read/write |
| vector | 0x0C | read/write |
| status | 0x10 | read, write-one-to-clear |
| capability | 0x14 | read-only |

Writes take effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

The output line is driven by a three-state trigger machine:

- `TRG_QUIET` means no enabled source is pending.
- `TRG_PULSE` is the first cycle after the pending set became non-empty.
- `TRG_HOLD` means the pending set is still non-empty.

The transitions are:

- `QUIET->PULSE` when something becomes pending.
- `PULSE->HOLD` and `HOLD->HOLD` while it stays pending.
- `PULSE->QUIET` and `HOLD->QUIET` once nothing is pending.

In level mode the line is active in `PULSE` and `HOLD`. In edge mode it is active only in `PULSE`. A parameter chooses the polarity.

Top module: `irq_event_unit`

## Requirements
- R1: After reset, the enable, vector and status registers read 0, and `irq_out` is at its inactive level. The inactive level is 0 when `ACTIVE_HIGH`=1 and 1 when `ACTIVE_HIGH`=0.
- R2: The enable register at offset 0x08 stores only these bits of a write: bit 31 (global enable), bit 7, bit 2, bit 1 and bit 0. All other bits read 0, so writing 0xFFFFFFFF reads back 0x80000087.
- R3: The vector register at offset 0x0C stores bits 7:0 of a write and returns them. Bits 31:8 read 0.
- R4: The status register is at offset 0x10. An event pulse sets its bit one edge later, whatever the enable register holds:
  - data available sets bit 0;
  - status valid sets bit 1;
  - locality change sets bit 2;
  - command ready sets bit 7.
- R5: A write to offset 0x10 clears exactly the status bits written as 1 and leaves the others unchanged. Writing back the value just read clears everything that was set.
- R6: If an event and a clearing write hit the same status bit in the same cycle, that bit stays set.
- R7: The capability word at offset 0x14 is read-only. Its bits are:
  - bits 0, 1, 2 and 7 are always 1;
  - bit 8 equals `BURST_STATIC`;
  - exactly one trigger bit is set: bit 3 for level high, bit 4 for level low, bit 5 for rising edge, bit 6 for falling edge.
  
  Writes to this offset change nothing.
- R8: While enable bit 31 is 0, `irq_out` stays inactive, or returns to inactive one edge after the bit is cleared.
- R9: In level mode (`EDGE_MODE`=0), `irq_out` is active from the second edge after the pending set becomes non-empty until the second edge after it becomes empty. The pending set is the status bits that are set and enabled, taken while bit 31 is 1.
- R10: In edge mode (`EDGE_MODE`=1), `irq_out` is active for exactly one cycle, on the second edge after the pending set goes from empty to non-empty. New events that arrive while the set is still non-empty give no further pulse.
- R11: When `ACTIVE_HIGH`=0 the output is inverted: active is 0 and inactive is 1.
- R12: Reads from offsets other than 0x08, 0x0C, 0x10 and 0x14 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_data_avail | input | 1 | Data-available event pulse |
| evt_sts_valid | input | 1 | Status-valid event pulse |
| evt_loc_change | input | 1 | Locality-change event pulse |
| evt_cmd_ready | input | 1 | Command-ready event pulse |
| irq_out | output | 1 | Host interrupt line |

## Verification
The assertions check four properties on every cycle:

- each event sets its status bit on the next edge;
- a one written to a status bit clears it unless an event arrives in the same cycle;
- status bits hold their value when neither happens;
- the output follows the pending set one edge later, or pulses for a single cycle in edge mode, and is never active while global enable is clear.

Three things only the bench scenarios can show:

- the register read values at each offset, including the fixed capability word for both trigger variants;
- the masking of unused enable and vector bits and the inertness of unmapped offsets;
- that a second event arriving while an interrupt is already pending gives no new edge pulse.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned N_SRC      = 4;
    localparam int unsigned OFS_ENABLE = 8;
    localparam int unsigned OFS_VECTOR = 12;
    localparam int unsigned OFS_STATUS = 16;
    localparam int unsigned OFS_CAPS   = 20;
    localparam int unsigned BIT_GLOBAL = 31;
    localparam int unsigned BIT_BURST  = 8;
    localparam int unsigned VEC_W      = 8;

    // source bits: data avail, status valid, locality change, command ready
    localparam logic [REG_W-1:0] SRC_MASK = 32'h0000_0087;
    localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK | (32'h1 << BIT_GLOBAL);

    typedef enum logic [1:0] {
        TRG_QUIET = 2'd0,
        TRG_PULSE = 2'd1,
        TRG_HOLD  = 2'd2
    } trg_state_e;

    // status bit position -> event index, or -1 when the bit is not a source
    function automatic int src_index(input int unsigned pos);
        int idx;
        case (pos)
            0:       idx = 0;
            1:       idx = 1;
            2:       idx = 2;
            7:       idx = 3;
            default: idx = -1;
        endcase
        return idx;
    endfunction

    function automatic logic [REG_W-1:0] caps_word(input bit edge_mode,
                                                   input bit active_high,
                                                   input bit burst_static);
        logic [REG_W-1:0] w;
        w = SRC_MASK;
        if (burst_static)
            w[BIT_BURST] = 1'b1;
        if (edge_mode)
            w[active_high ? 5 : 6] = 1'b1;
        else
            w[active_high ? 3 : 4] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/irq_unit_status.sv
module irq_unit_status
    import irq_unit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] status_q
);

    logic unused_clr_bits;
    assign unused_clr_bits = ^(clr_data & ~SRC_MASK);

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        localparam int SI = src_index(b);
        if (SI >= 0) begin : g_src
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (evt[SI])
                    bit_q <= 1'b1;
                else if (clr_we && clr_data[b])
                    bit_q <= 1'b0;
            end
            assign status_q[b] = bit_q;
        end else begin : g_none
            assign status_q[b] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_unit_regs.sv
module irq_unit_regs
    import irq_unit_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter bit          EDGE_MODE    = 1'b0,
    parameter bit          ACTIVE_HIGH  = 1'b1,
    parameter bit          BURST_STATIC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [REG_W-1:0]  status_q,
    output logic [REG_W-1:0]  en_q,
    output logic [REG_W-1:0]  bus_rdata
);

    localparam logic [REG_W-1:0]  CAPS   = caps_word(EDGE_MODE, ACTIVE_HIGH, BURST_STATIC);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(OFS_VECTOR);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CAPS = ADDR_W'(OFS_CAPS);

    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            vec_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_EN)
                en_q <= bus_wdata & EN_MASK;
            if (bus_addr == A_VEC)
                vec_q <= bus_wdata[VEC_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_EN)
            bus_rdata = en_q;
        else if (bus_addr == A_VEC)
            bus_rdata = {{(REG_W-VEC_W){1'b0}}, vec_q};
        else if (bus_addr == A_STS)
            bus_rdata = status_q;
        else if (bus_addr == A_CAPS)
            bus_rdata = CAPS;
    end

endmodule

// File: rtl/irq_unit_trigger.sv
module irq_unit_trigger
    import irq_unit_pkg::*;
#(
    parameter bit EDGE_MODE   = 1'b0,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_out
);

    trg_state_e state_q, state_d;
    logic       active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TRG_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = TRG_QUIET;
        unique case (state_q)
            TRG_QUIET: state_d = pending ? TRG_PULSE : TRG_QUIET;
            TRG_PULSE: state_d = pending ? TRG_HOLD  : TRG_QUIET;
            TRG_HOLD:  state_d = pending ? TRG_HOLD  : TRG_QUIET;
            default:   state_d = TRG_QUIET;
        endcase
    end

    if (EDGE_MODE) begin : g_edge
        always_comb active = (state_q == TRG_PULSE);
    end else begin : g_level
        always_comb active = (state_q != TRG_QUIET);
    end

    always_comb irq_out = ACTIVE_HIGH ? active : ~active;

endmodule

// File: rtl/irq_event_unit.sv
module irq_event_unit
    import irq_unit_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter bit          EDGE_MODE    = 1'b0,
    parameter bit          ACTIVE_HIGH  = 1'b1,
    parameter bit          BURST_STATIC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              evt_data_avail,
    input  logic              evt_sts_valid,
    input  logic              evt_loc_change,
    input  logic              evt_cmd_ready,
    output logic              irq_out
);

    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);

    logic [N_SRC-1:0] evt_vec;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] status_q;
    logic             sts_clr_we;
    logic             pending;

    assign evt_vec    = {evt_cmd_ready, evt_loc_change, evt_sts_valid, evt_data_avail};
    assign sts_clr_we = bus_wr && (bus_addr == A_STS);
    assign pending    = en_q[BIT_GLOBAL] && (|(status_q & en_q & SRC_MASK));

    irq_unit_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_vec),
        .clr_we   (sts_clr_we),
        .clr_data (bus_wdata),
        .status_q (status_q)
    );

    irq_unit_regs #(
        .ADDR_W       (ADDR_W),
        .EDGE_MODE    (EDGE_MODE),
        .ACTIVE_HIGH  (ACTIVE_HIGH),
        .BURST_STATIC (BURST_STATIC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .status_q  (status_q),
        .en_q      (en_q),
        .bus_rdata (bus_rdata)
    );

    irq_unit_trigger #(
        .EDGE_MODE   (EDGE_MODE),
        .ACTIVE_HIGH (ACTIVE_HIGH)
    ) u_trigger (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/irq_event_unit_chk.sv
module irq_event_unit_chk
    import irq_unit_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter bit          EDGE_MODE   = 1'b0,
    parameter bit          ACTIVE_HIGH = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [N_SRC-1:0]  evt,
    input logic [REG_W-1:0]  en_q,
    input logic [REG_W-1:0]  status_q,
    input logic              irq_out
);

    logic             act;
    logic             pend;
    logic [REG_W-1:0] clr_bits;
    logic             unused_chk;

    assign act        = ACTIVE_HIGH ? irq_out : ~irq_out;
    assign pend       = en_q[BIT_GLOBAL] && (|(status_q & en_q & SRC_MASK));
    assign clr_bits   = (bus_wr && bus_addr == ADDR_W'(OFS_STATUS)) ? bus_wdata : '0;
    assign unused_chk = ^clr_bits;

    a_r4_data_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> status_q[0]);

    a_r4_cmd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt[3] |=> status_q[7]);

    a_r5_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits[1] && !evt[1]) |=> !status_q[1]);

    a_r5_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_bits[1] && !evt[1]) |=> $stable(status_q[1]));

    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits[0] && evt[0]) |=> status_q[0]);

    a_r8_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[BIT_GLOBAL] |=> !act);

    if (EDGE_MODE) begin : g_edge_chk
        a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            act |=> !act);
        a_r10_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !pend |=> !act);
    end else begin : g_level_chk
        a_r9_follow_on: assert property (@(posedge clk) disable iff (!rst_n)
            pend |=> act);
        a_r9_follow_off: assert property (@(posedge clk) disable iff (!rst_n)
            !pend |=> !act);
    end

endmodule

bind irq_event_unit irq_event_unit_chk #(
    .ADDR_W      (ADDR_W),
    .EDGE_MODE   (EDGE_MODE),
    .ACTIVE_HIGH (ACTIVE_HIGH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt       (evt_vec),
    .en_q      (en_q),
    .status_q  (status_q),
    .irq_out   (irq_out)
);

// File: tb/irq_event_unit_test.sv
`timescale 1ns/1ps
module irq_event_unit_test;

    localparam int K_RD   = 0;
    localparam int K_IRQ  = 1;
    localparam int K_IRQE = 2;
    localparam int K_RDE  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] rdata_l, rdata_e;
    logic [3:0]  evt = 4'h0;
    logic        irq_l, irq_e;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #2 clk = ~clk;

    irq_event_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_l),
        .evt_data_avail(evt[0]), .evt_sts_valid(evt[1]),
        .evt_loc_change(evt[2]), .evt_cmd_ready(evt[3]), .irq_out(irq_l)
    );

    irq_event_unit #(.EDGE_MODE(1'b1), .ACTIVE_HIGH(1'b0)) uut_edge (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_e),
        .evt_data_avail(evt[0]), .evt_sts_valid(evt[1]),
        .evt_loc_change(evt[2]), .evt_cmd_ready(evt[3]), .irq_out(irq_e)
    );

    // monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t       it;
            logic [31:0] actual;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    actual = rdata_l;
                K_RDE:   actual = rdata_e;
                K_IRQ:   actual = {31'b0, irq_l};
                default: actual = {31'b0, irq_e};
            endcase
            n_cmp++;
            if (actual !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, actual, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        push(K_RD, exp, tag);
        tick();
    endtask

    task automatic rd_edge(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        push(K_RDE, exp, tag);
        tick();
    endtask

    task automatic pulse(input logic [3:0] m);
        evt = m;
        tick();
        evt = 4'h0;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        push(K_IRQ,  32'h0, "R1 level irq inactive");
        push(K_IRQE, 32'h1, "R1 R11 edge irq inactive high");
        rd(8'h08, 32'h0, "R1 enable reset");
        rd(8'h0C, 32'h0, "R1 vector reset");
        rd(8'h10, 32'h0, "R1 status reset");
        // R7 capability words
        rd(8'h14, 32'h0000_018F, "R7 caps level/high");
        rd_edge(8'h14, 32'h0000_01C7, "R7 caps edge/falling");
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, 32'h0000_018F, "R7 caps write ignored");
        // R2 enable masking
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h8000_0087, "R2 enable mask");
        wr(8'h08, 32'h0);
        // R3 vector
        wr(8'h0C, 32'h0000_01A5);
        rd(8'h0C, 32'h0000_00A5, "R3 vector 8 bit");
        // R12 unmapped offset
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R12 unmapped read");
        rd(8'h08, 32'h0, "R12 enable untouched");
        rd(8'h0C, 32'h0000_00A5, "R12 vector untouched");
        // R4 event with all enables off, R8 no interrupt
        pulse(4'b0001);
        rd(8'h10, 32'h1, "R4 data avail sets bit0");
        push(K_IRQ, 32'h0, "R8 no irq enables off");
        // R8 source enabled but global off
        wr(8'h08, 32'h0000_0001);
        tick();
        tick();
        push(K_IRQ, 32'h0, "R8 global off gates");
        push(K_IRQE, 32'h1, "R8 edge gated");
        // R9 R10 R11 global on
        wr(8'h08, 32'h8000_0001);
        push(K_IRQ,  32'h0, "R9 not yet active");
        push(K_IRQE, 32'h1, "R10 not yet pulsing");
        tick();
        push(K_IRQ,  32'h1, "R9 level active");
        push(K_IRQE, 32'h0, "R10 R11 edge pulse low");
        tick();
        push(K_IRQ,  32'h1, "R9 level held");
        push(K_IRQE, 32'h1, "R10 pulse one cycle");
        // R10 extra event while pending: no new pulse
        pulse(4'b0010);
        tick();
        push(K_IRQE, 32'h1, "R10 no repulse");
        tick();
        push(K_IRQE, 32'h1, "R10 no repulse later");
        rd(8'h10, 32'h3, "R4 status valid sets bit1");
        // R5 clear one bit, R9 drop
        wr(8'h10, 32'h1);
        push(K_IRQ, 32'h1, "R9 still active one edge");
        tick();
        push(K_IRQ,  32'h0, "R9 level released");
        push(K_IRQE, 32'h1, "R10 edge idle");
        rd(8'h10, 32'h2, "R5 only bit0 cleared");
        wr(8'h10, 32'h2);
        rd(8'h10, 32'h0, "R5 write back clears");
        // R6 event and clear collide
        pulse(4'b1000);
        rd(8'h10, 32'h80, "R4 cmd ready sets bit7");
        evt = 4'b1000; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h80;
        tick();
        evt = 4'h0; bus_wr = 1'b0;
        rd(8'h10, 32'h80, "R6 event wins over clear");
        wr(8'h10, 32'h80);
        rd(8'h10, 32'h0, "R5 bit7 cleared");
        // R10 fresh pulse after empty
        pulse(4'b1000);
        wr(8'h08, 32'h8000_0080);
        push(K_IRQE, 32'h1, "R10 before second pulse");
        tick();
        push(K_IRQE, 32'h0, "R10 second pulse");
        push(K_IRQ,  32'h1, "R9 active on bit7");
        tick();
        push(K_IRQE, 32'h1, "R10 second pulse ends");
        // R8 clearing global releases line
        wr(8'h08, 32'h0000_0080);
        push(K_IRQ, 32'h1, "R8 one edge latency");
        tick();
        push(K_IRQ, 32'h0, "R8 global cleared");
        // R4 locality change
        pulse(4'b0100);
        rd(8'h10, 32'h84, "R4 locality sets bit2");
        tick();
        done = 1'b1;
        report();
    end

endmodule